// File: doc/BRIEF.md
# Reset Source Combiner with Cause Register

This block merges ten independent reset requests into one active-high system reset. The requests are power-on, brown-out, an active-low master-clear pin, a reset-instruction strobe, a watchdog timeout, a configuration mismatch, a trap conflict, and three illegal-condition flags: illegal opcode, uninitialized working register and security violation. The master-clear pin is counted only after a run of consecutive low samples. Once the last request has gone away, the system reset stays asserted for a fixed number of extra cycles.

A 16-bit cause register records which requests have occurred. Each request sets its own sticky bit. Power-on clears every other bit and leaves only its own bit set. Software can overwrite the cause bits at any time through a write strobe and data word. Such a write changes the stored status only and never asserts the reset. The register value is always visible on a read port.

Top module: `rst_combiner`

## Requirements
- R1: While any request is active (`mclr_n` counted only once filtered), `sys_rst` is high in the same cycle, with no clock edge in between.
- R2: After the last active request releases, `sys_rst` stays high for exactly HOLD_LEN (default 8) further rising edges and then goes low.
- R3: `mclr_n` is active low. It counts as a request only after it has been sampled low on FILT_LEN (default 4) consecutive rising edges. A shorter low pulse neither raises `sys_rst` nor sets its cause bit.
- R4: Cause bit positions are fixed: 0 power-on, 1 brown-out, 2 master-clear, 3 reset instruction, 4 watchdog, 5 configuration mismatch, 6 trap conflict, 7 illegal opcode, 8 uninitialized working register, 9 security violation.
- R5: A request that is active at a rising edge sets its cause bit at that edge. The bit stays set after the request goes away.
- R6: While `por_req` is high, each rising edge loads the cause register with 0x0001. Every other recorded cause is erased, whatever else is active.
- R7: When `reg_we` is high at a rising edge, bits 9:0 take `reg_wdata[9:0]`. A write alone never raises `sys_rst`.
- R8: When a request and a write meet at the same edge, the request's bit ends up set, and the other bits take the written value.
- R9: `reg_rdata[15:10]` always read as zero, even after writing ones there.
- R10: Each of the three illegal-condition inputs raises `sys_rst` on its own and sets its own bit (7, 8 or 9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_req | input | 1 | Power-on detect, active high |
| bor_req | input | 1 | Brown-out detect, active high |
| mclr_n | input | 1 | Master-clear pin, active low, filtered |
| swrst_req | input | 1 | Reset-instruction strobe |
| wdt_req | input | 1 | Watchdog timeout |
| cfgmis_req | input | 1 | Configuration mismatch |
| trapc_req | input | 1 | Trap conflict |
| illop_req | input | 1 | Illegal opcode |
| uninitw_req | input | 1 | Uninitialized working register use |
| secv_req | input | 1 | Security violation |
| reg_we | input | 1 | Cause register write strobe |
| reg_wdata | input | 16 | Cause register write data |
| reg_rdata | output | 16 | Cause register read data |
| sys_rst | output | 1 | Combined system reset, active high |

## Verification
`sys_rst` follows a request with no edge in between, so the bench drives at the falling edge and reads it one time step later. A cause bit or a written value appears after the next rising edge, so the bench reads `reg_rdata` at the falling edge after that edge. Release of the reset is due after the HOLD_LEN-th rising edge with no request. The master-clear filter fires at the FILT_LEN-th consecutive low edge. The bench counts edges for both windows and samples on each side of the expected edge.

// File: rtl/rst_combiner.sv
`timescale 1ns/1ps
module rst_combiner #(
  parameter int FILT_LEN = 4,
  parameter int HOLD_LEN = 8
) (
  input  logic        clk,
  input  logic        por_req,
  input  logic        bor_req,
  input  logic        mclr_n,
  input  logic        swrst_req,
  input  logic        wdt_req,
  input  logic        cfgmis_req,
  input  logic        trapc_req,
  input  logic        illop_req,
  input  logic        uninitw_req,
  input  logic        secv_req,
  input  logic        reg_we,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        sys_rst
);
  localparam int NSRC = 10;
  localparam int FW   = $clog2(FILT_LEN + 1);
  localparam int HW   = $clog2(HOLD_LEN + 1);

  logic [FW-1:0]   low_cnt;
  logic [HW-1:0]   hold_cnt;
  logic [NSRC-1:0] stat;
  logic [NSRC-1:0] src_vec;
  logic            mclr_hit;
  logic            any_src;

  always_ff @(posedge clk) begin
    if (por_req || mclr_n)
      low_cnt <= '0;
    else if (low_cnt != FW'(FILT_LEN))
      low_cnt <= low_cnt + 1'b1;
  end

  assign mclr_hit = (low_cnt == FW'(FILT_LEN));

  assign src_vec = {secv_req, uninitw_req, illop_req, trapc_req, cfgmis_req,
                    wdt_req, swrst_req, mclr_hit, bor_req, por_req};
  assign any_src = |src_vec;

  always_ff @(posedge clk) begin
    if (any_src)
      hold_cnt <= HW'(HOLD_LEN);
    else if (hold_cnt != '0)
      hold_cnt <= hold_cnt - 1'b1;
  end

  assign sys_rst = any_src || (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (por_req)
      stat <= NSRC'(1);
    else
      stat <= (reg_we ? reg_wdata[NSRC-1:0] : stat) | src_vec;
  end

  assign reg_rdata = {{(16-NSRC){1'b0}}, stat};
endmodule

module rst_combiner_chk #(
  parameter int FILT_LEN = 4,
  parameter int HOLD_LEN = 8
) (
  input logic        clk,
  input logic        por_req,
  input logic        mclr_n,
  input logic [9:0]  src_vec,
  input logic        any_src,
  input logic        mclr_hit,
  input logic        sys_rst,
  input logic [15:0] reg_rdata
);
  int idle_run;
  int low_run;

  always_ff @(posedge clk) begin
    if (por_req || any_src) idle_run <= 0;
    else if (idle_run < HOLD_LEN) idle_run <= idle_run + 1;
    if (por_req || mclr_n) low_run <= 0;
    else if (low_run < FILT_LEN) low_run <= low_run + 1;
  end

  // R1
  src_forces_rst_chk: assert property (@(posedge clk) disable iff (por_req)
    any_src |-> sys_rst);

  // R2
  hold_window_chk: assert property (@(posedge clk) disable iff (por_req)
    !sys_rst |-> (idle_run == HOLD_LEN));

  // R7
  rst_rise_cause_chk: assert property (@(posedge clk) disable iff (por_req)
    $rose(sys_rst) |-> any_src);

  // R3
  mclr_filter_chk: assert property (@(posedge clk) disable iff (por_req)
    mclr_hit |-> (low_run >= FILT_LEN));

  // R5
  cause_set_chk: assert property (@(posedge clk) disable iff (por_req)
    1'b1 |=> ((reg_rdata[9:0] & $past(src_vec)) == $past(src_vec)));

  // R6
  por_bit_chk: assert property (@(posedge clk) disable iff (por_req)
    $fell(por_req) |-> reg_rdata[0]);

  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (por_req)
    reg_rdata[15:10] == 6'd0);
endmodule

bind rst_combiner rst_combiner_chk #(.FILT_LEN(FILT_LEN), .HOLD_LEN(HOLD_LEN)) u_chk (
  .clk(clk), .por_req(por_req), .mclr_n(mclr_n), .src_vec(src_vec),
  .any_src(any_src), .mclr_hit(mclr_hit), .sys_rst(sys_rst), .reg_rdata(reg_rdata)
);

// File: tb/rst_combiner_bench.sv
`timescale 1ns/1ps
module rst_combiner_bench;
  logic clk = 1'b0;
  logic por_req = 1'b1;
  logic mclr_n = 1'b1;
  logic [9:0] req = '0;
  logic reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic sys_rst;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rst_combiner u_rst_combiner (
    .clk(clk), .por_req(por_req), .bor_req(req[1]), .mclr_n(mclr_n),
    .swrst_req(req[3]), .wdt_req(req[4]), .cfgmis_req(req[5]), .trapc_req(req[6]),
    .illop_req(req[7]), .uninitw_req(req[8]), .secv_req(req[9]),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sys_rst(sys_rst)
  );

  // {we, wdata, requests (bit0/bit2 unused here), expected rdata after edge}
  typedef struct packed {
    logic        we;
    logic [15:0] wd;
    logic [9:0]  rq;
    logic [15:0] exp;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b1, 16'h0000, 10'h000, 16'h0000},
    '{1'b0, 16'h0000, 10'h002, 16'h0002},
    '{1'b1, 16'h0000, 10'h000, 16'h0000},
    '{1'b0, 16'h0000, 10'h010, 16'h0010},
    '{1'b0, 16'h0000, 10'h048, 16'h0058},
    '{1'b1, 16'hFFFF, 10'h000, 16'h03FF},
    '{1'b1, 16'h0000, 10'h020, 16'h0020},
    '{1'b1, 16'h0001, 10'h200, 16'h0201},
    '{1'b1, 16'h0000, 10'h080, 16'h0080},
    '{1'b1, 16'h0000, 10'h100, 16'h0100},
    '{1'b1, 16'h0084, 10'h000, 16'h0084}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    #1 chk("R1 por drives sys_rst", {15'd0, sys_rst}, 16'd1);
    edges(2);
    chk("R6 reset state", reg_rdata, 16'h0001);
    por_req = 1'b0;
    edges(HOLD_WAIT);

    foreach (VECS[k]) begin
      reg_we = VECS[k].we; reg_wdata = VECS[k].wd; req = VECS[k].rq;
      #1 chk((VECS[k].rq != 0) ? "R1 request raises sys_rst" : "R7 write alone no reset",
             {15'd0, sys_rst}, {15'd0, |VECS[k].rq});
      @(negedge clk);
      reg_we = 1'b0; req = '0;
      chk(VECS[k].rq[7] || VECS[k].rq[8] || VECS[k].rq[9] ? "R10 illegal cause bit" :
          (VECS[k].we && VECS[k].rq != 0) ? "R8 request beats write" :
          VECS[k].we ? "R7 R9 write value" : "R4 R5 cause bit", reg_rdata, VECS[k].exp);
      edges(HOLD_WAIT);
      chk("R2 reset released", {15'd0, sys_rst}, 16'd0);
    end

    reg_we = 1'b1; reg_wdata = 16'h0000; @(negedge clk); reg_we = 1'b0;
    req[1] = 1'b1; @(negedge clk); req = '0;
    edges(7);
    chk("R2 still held after 7 edges", {15'd0, sys_rst}, 16'd1);
    edges(1);
    chk("R2 released after 8 edges", {15'd0, sys_rst}, 16'd0);
    chk("R5 sticky bit", reg_rdata, 16'h0002);

    reg_we = 1'b1; reg_wdata = 16'h0000; @(negedge clk); reg_we = 1'b0;
    mclr_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R3 short low ignored", {15'd0, sys_rst}, 16'd0);
    end
    mclr_n = 1'b1;
    edges(2);
    chk("R3 short pulse no cause", reg_rdata, 16'h0000);
    mclr_n = 1'b0;
    edges(3);
    chk("R3 three lows not yet", {15'd0, sys_rst}, 16'd0);
    edges(1);
    chk("R3 fourth low fires", {15'd0, sys_rst}, 16'd1);
    edges(1);
    mclr_n = 1'b1;
    chk("R3 R4 mclr bit2", reg_rdata, 16'h0004);
    edges(HOLD_WAIT);

    reg_we = 1'b1; reg_wdata = 16'h03FE; @(negedge clk); reg_we = 1'b0;
    chk("R7 write all causes", reg_rdata, 16'h03FE);
    por_req = 1'b1; req = 10'h3FA;
    @(negedge clk);
    por_req = 1'b0; req = '0;
    chk("R6 por wipes others", reg_rdata, 16'h0001);
    edges(HOLD_WAIT);
    chk("R2 quiet after por", {15'd0, sys_rst}, 16'd0);

    finish_run();
  end

  localparam int HOLD_WAIT = 12;
endmodule